// File: doc/BRIEF.md
# Infrared serial pulse codec

This block sits between a UART-style serial engine and an infrared transceiver, and runs on the 14.7456 MHz reference clock. On the transmit side it watches the NRZ line from the UART. For every zero bit it sends one short light pulse, and for every one bit it sends nothing. On the receive side it takes pulses from the photodiode. Each detected pulse is widened back into a zero bit that lasts a full bit period, and that zero is handed to the UART receiver.

A baud generator divides the reference clock by a 16-bit divisor to produce the UART's 16x sample tick. A bit period is therefore 16 times the divisor, in reference cycles. The divisor is written as two bytes. It is only taken into use while the UART reports that no character is in flight.

Each direction has its own IR enable. With the enable cleared, that direction carries plain UART levels. The out-of-reset arrangement is half duplex: receive in IR mode and transmit in UART mode. Software swaps the two enables around a frame. The pulse width can be set to 3/16 of a bit or to a fixed 24 reference cycles, about 1.6 us. Transmit polarity and receive polarity are set independently.

Top module: `irsir_codec`

## Requirements
- R1: After reset, the settings are as follows:
  - transmit is in UART mode;
  - receive is in IR mode;
  - the pulse width is 3/16 of a bit;
  - both polarities are non-inverted;
  - the divisor is 96.
  After reset, `ir_tx` and `uart_rxd` are both 1.
- R2: Writes go through `wr_en`/`wr_addr`/`wr_data`, and the register map is:
  - address 0 holds the divisor low byte;
  - address 1 holds the divisor high byte;
  - address 2 is control, with bit 0 the transmit IR enable, bit 1 the receive IR enable, bit 2 the fixed-width select, bit 3 transmit invert and bit 4 receive invert.

  `baud16_tick` pulses for one cycle once every D reference cycles, where D is the divisor in use. A divisor of 0 acts as 1.
- R3: A written divisor is taken into use only while `tx_busy` is low. While `tx_busy` is high, the tick spacing and bit timing keep the previous divisor.
- R4: With transmit IR enabled, a zero bit gives one pulse of 3·D cycles at the start of the bit. A one bit gives no pulse, so the output stays at idle for that whole bit. The pulse output rises one edge after the edge that samples the start of the zero bit.
- R5: With fixed width selected, each zero-bit pulse lasts exactly 24 reference cycles.
- R6: With transmit invert clear, the idle level is 0 and a pulse is 1. With transmit invert set, both levels are swapped.
- R7: With transmit IR disabled, `ir_tx` carries `uart_txd` unencoded and uninverted, one edge later.
- R8: With receive IR enabled, a pulse sampled at edge A drives `uart_rxd` to 0 from edge A+3 through edge A+16·D+2. Pulses in consecutive bits merge into one continuous zero.
- R9: With receive invert clear, a high input is a pulse. With receive invert set, a low input is a pulse.
- R10: With receive IR disabled, `uart_rxd` carries `ir_rx` raw, two edges after the edge that samples it. The receive invert setting has no effect in this mode.
- R11: An input pulse that begins and ends between two reference edges has no effect on `uart_rxd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (14.7456 MHz in use) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| uart_txd | input | 1 | NRZ transmit line from the UART |
| tx_busy | input | 1 | High while the UART is sending a character |
| ir_rx | input | 1 | Raw receive line from the transceiver |
| ir_tx | output | 1 | Drive to the infrared emitter |
| uart_rxd | output | 1 | NRZ receive line to the UART |
| baud16_tick | output | 1 | 16x bit-rate sample tick for the UART |

## Verification
Each result has a fixed latency in edges:
- The IR transmit pulse appears one edge after the edge that samples the NRZ level, and the transmit passthrough appears on that same edge.
- A received pulse turns into a zero three edges after its sampling edge, and the receive passthrough lags by two edges.
- Tick spacing is measured in edges between consecutive ticks.

Stimulus is applied and outputs are read 1 ns after each rising edge. The expected waveform of each frame is a function of the edge count since the first driven bit. Every sample therefore has a known cycle, whatever the divisor, width mode or polarity. Random frames, random divisors and random polarities are mixed with directed all-zero, all-one and sub-cycle glitch cases.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

  // Control register image; packed MSB first so field i sits at wr_data[i].
  typedef struct packed {
    logic rx_inv;   // bit 4
    logic tx_inv;   // bit 3
    logic fixed_w;  // bit 2
    logic rx_ir;    // bit 1
    logic tx_ir;    // bit 0
  } irsir_ctrl_t;

  localparam int CTRL_W = $bits(irsir_ctrl_t);

  typedef enum logic [1:0] {
    ADDR_DIV_LO = 2'd0,
    ADDR_DIV_HI = 2'd1,
    ADDR_CTRL   = 2'd2
  } irsir_addr_t;

endpackage

// File: rtl/irsir_regs.sv
module irsir_regs
  import irsir_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int RESET_DIV = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             tx_busy,
  output irsir_ctrl_t      ctrl,
  output logic [DIV_W-1:0] act_div
);

  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(RESET_DIV);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] stage_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_div <= DIV_RST;
      act_div   <= DIV_RST;
      ctrl      <= '{rx_inv: 1'b0, tx_inv: 1'b0, fixed_w: 1'b0,
                     rx_ir: 1'b1, tx_ir: 1'b0};
    end else begin
      if (wr_en) begin
        case (irsir_addr_t'(wr_addr))
          ADDR_DIV_LO: stage_div[7:0]       <= wr_data;
          ADDR_DIV_HI: stage_div[DIV_W-1:8] <= wr_data[DIV_W-9:0];
          ADDR_CTRL:   ctrl                 <= irsir_ctrl_t'(wr_data[CTRL_W-1:0]);
          default: ;
        endcase
      end
      // Character boundary: adopt the staged divisor only while idle.
      if (!tx_busy)
        act_div <= (stage_div == '0) ? DIV_ONE : stage_div;
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(act_div)) else $error("divisor moved mid-character"); // R3

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
    act_div != '0) else $error("divisor in use is zero"); // R2

endmodule

// File: rtl/irsir_baud.sv
module irsir_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && div > DIV_W'(1)) |=> !tick) else $error("ticks too close"); // R2

endmodule

// File: rtl/irsir_enc.sv
module irsir_enc #(
  parameter int DIV_W            = 16,
  parameter int OVERSAMPLE       = 16,
  parameter int PULSE_SIXTEENTHS = 3,
  parameter int FIXED_PULSE_CYC  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_ir,
  input  logic             fixed_w,
  input  logic             tx_inv,
  input  logic             uart_txd,
  output logic             ir_tx
);

  localparam int LEN_W = DIV_W + $clog2(OVERSAMPLE) + 1;

  logic [LEN_W-1:0] bit_len, pulse_len, bit_cnt, pulse_rem;
  logic             txd_q, bit_start;

  assign bit_len   = LEN_W'(div) * LEN_W'(OVERSAMPLE);
  assign pulse_len = fixed_w ? LEN_W'(FIXED_PULSE_CYC)
                             : LEN_W'(div) * LEN_W'(PULSE_SIXTEENTHS);
  // A level change resynchronises the bit grid; otherwise it free-runs.
  assign bit_start = (uart_txd != txd_q) || (bit_cnt >= bit_len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q     <= 1'b1;
      bit_cnt   <= '0;
      pulse_rem <= '0;
      ir_tx     <= 1'b1;
    end else begin
      txd_q   <= uart_txd;
      bit_cnt <= bit_start ? '0 : bit_cnt + LEN_W'(1);
      if (bit_start)
        pulse_rem <= uart_txd ? '0 : pulse_len;
      else if (pulse_rem != '0)
        pulse_rem <= pulse_rem - LEN_W'(1);
      ir_tx <= tx_ir ? ((pulse_rem != '0) ^ tx_inv) : uart_txd;
    end
  end

  AST_MARK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (bit_start && uart_txd) |=> pulse_rem == '0) else $error("pulse on a one bit"); // R4

  AST_ZERO_FIRES: assert property (@(posedge clk) disable iff (rst)
    (bit_start && !uart_txd) |=> pulse_rem != '0) else $error("zero bit without pulse"); // R4

endmodule

// File: rtl/irsir_dec.sv
module irsir_dec #(
  parameter int DIV_W       = 16,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             rx_ir,
  input  logic             rx_inv,
  input  logic             ir_rx,
  output logic             uart_rxd
);

  localparam int LEN_W = DIV_W + $clog2(OVERSAMPLE) + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LEN_W-1:0]       st_rem;
  logic                   lvl, lvl_q, rise, raw;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], ir_rx};
  end

  assign raw  = sync_q[SYNC_STAGES-1];
  assign lvl  = raw ^ rx_inv;
  assign rise = lvl && !lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= 1'b1;
      st_rem   <= '0;
      uart_rxd <= 1'b1;
    end else begin
      lvl_q <= lvl;
      if (rise)
        st_rem <= LEN_W'(div) * LEN_W'(OVERSAMPLE);
      else if (st_rem != '0)
        st_rem <= st_rem - LEN_W'(1);
      uart_rxd <= rx_ir ? (st_rem == '0) : raw;
    end
  end

  AST_RISE_ARMS: assert property (@(posedge clk) disable iff (rst)
    rise |=> st_rem != '0) else $error("pulse not stretched"); // R8

  AST_STRETCH_LOW: assert property (@(posedge clk) disable iff (rst)
    (rx_ir && st_rem != '0) |=> !uart_rxd) else $error("zero bit broken"); // R8

endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int DIV_W            = 16,
  parameter int RESET_DIV        = 96,
  parameter int OVERSAMPLE       = 16,
  parameter int PULSE_SIXTEENTHS = 3,
  parameter int FIXED_PULSE_CYC  = 24,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       uart_txd,
  input  logic       tx_busy,
  input  logic       ir_rx,
  output logic       ir_tx,
  output logic       uart_rxd,
  output logic       baud16_tick
);

  irsir_ctrl_t      ctrl;
  logic [DIV_W-1:0] act_div;

  irsir_regs #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_busy(tx_busy), .ctrl(ctrl), .act_div(act_div)
  );

  irsir_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(act_div), .tick(baud16_tick)
  );

  irsir_enc #(
    .DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE),
    .PULSE_SIXTEENTHS(PULSE_SIXTEENTHS), .FIXED_PULSE_CYC(FIXED_PULSE_CYC)
  ) u_enc (
    .clk(clk), .rst(rst), .div(act_div), .tx_ir(ctrl.tx_ir),
    .fixed_w(ctrl.fixed_w), .tx_inv(ctrl.tx_inv), .uart_txd(uart_txd), .ir_tx(ir_tx)
  );

  irsir_dec #(
    .DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)
  ) u_dec (
    .clk(clk), .rst(rst), .div(act_div), .rx_ir(ctrl.rx_ir),
    .rx_inv(ctrl.rx_inv), .ir_rx(ir_rx), .uart_rxd(uart_rxd)
  );

endmodule

// File: tb/irsir_codec_test.sv
`timescale 1ns/1ps
module irsir_codec_test;

  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       uart_txd = 1'b1, tx_busy = 1'b0, ir_rx = 1'b0;
  logic       ir_tx, uart_rxd, baud16_tick;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irsir_codec uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .uart_txd(uart_txd), .tx_busy(tx_busy), .ir_rx(ir_rx),
    .ir_tx(ir_tx), .uart_rxd(uart_rxd), .baud16_tick(baud16_tick)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_div(int d);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
  endtask

  function automatic logic [7:0] ctl(bit txe, bit rxe, bit fx, bit tinv, bit rinv);
    return {3'b000, rinv, tinv, fx, rxe, txe};
  endfunction

  // Expected emitter level after edge E+m, where edge E samples the start bit.
  function automatic bit exp_tx(int m, logic [9:0] fr, int len, int w, bit pol);
    int mp, k;
    if (m == 0) return pol;
    mp = m - 1;
    k  = mp / len;
    if (k > 9) return pol;
    return ((fr[k] == 1'b0) && ((mp % len) < w)) ^ pol;
  endfunction

  // Expected receive line after edge A+m, where edge A samples the first pulse.
  function automatic bit exp_rx(int m, logic [9:0] fr, int len);
    for (int k = 0; k < 10; k++)
      if (fr[k] == 1'b0 && (m - k*len) >= 3 && (m - k*len) <= len + 2) return 1'b0;
    return 1'b1;
  endfunction

  task automatic tick_period(output int per);
    int c = 0;
    while (!baud16_tick && c < 100000) begin step(); c++; end
    c = 0;
    do begin step(); c++; end while (!baud16_tick && c < 100000);
    per = c;
  endtask

  task automatic tx_frame(logic [7:0] data, int d, bit fx, bit pol, string req);
    logic [9:0] fr = {1'b1, data, 1'b0};
    int len = 16*d, w = fx ? 24 : 3*d, bad = 0, fa = 0, fe = 0, n;
    bit e;
    set_div(d);
    wr(2'd2, ctl(1'b1, 1'b1, fx, pol, 1'b0));
    uart_txd = 1'b1; tx_busy = 1'b0;
    idle(100);
    tx_busy = 1'b1;
    uart_txd = fr[0];
    for (int m = 0; m <= 10*len + 2; m++) begin
      step();
      n = (m + 1) / len;
      uart_txd = (n <= 9) ? fr[n] : 1'b1;
      e = exp_tx(m, fr, len, w, pol);
      if (ir_tx !== e) begin
        if (bad == 0) begin fa = int'(ir_tx); fe = int'(e); end
        bad++;
      end
    end
    tx_busy = 1'b0;
    chk(bad == 0, req, fa, fe);
  endtask

  task automatic rx_frame(logic [7:0] data, int d, bit pol, string req);
    logic [9:0] fr = {1'b1, data, 1'b0};
    int len = 16*d, bad = 0, fa = 0, fe = 0, n, k;
    bit e;
    set_div(d);
    wr(2'd2, ctl(1'b0, 1'b1, 1'b0, 1'b0, pol));
    ir_rx = pol; tx_busy = 1'b0;
    idle(100);
    ir_rx = ~pol;
    for (int m = 0; m <= 10*len + 5; m++) begin
      step();
      n = m + 1;
      k = n / len;
      ir_rx = (k <= 9 && fr[k] == 1'b0 && (n % len) < 2) ? ~pol : pol;
      e = exp_rx(m, fr, len);
      if (uart_rxd !== e) begin
        if (bad == 0) begin fa = int'(uart_rxd); fe = int'(e); end
        bad++;
      end
    end
    chk(bad == 0, req, fa, fe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int per, bad, h0, h1, h2, r;
    void'($urandom(32'd7919));
    idle(5);
    rst = 1'b0;
    idle(3);
    // R1: idle outputs after reset
    chk(ir_tx === 1'b1, "R1 ir_tx", int'(ir_tx), 1);
    chk(uart_rxd === 1'b1, "R1 uart_rxd", int'(uart_rxd), 1);
    tick_period(per);
    chk(per == 96, "R1 reset divisor", per, 96);
    // R1: transmit passthrough out of reset
    uart_txd = 1'b0; step();
    chk(ir_tx === 1'b0, "R1 tx in UART mode", int'(ir_tx), 0);
    uart_txd = 1'b1; step();
    // R1: receive in IR mode out of reset (pulse gets stretched)
    ir_rx = 1'b1; step(); step();
    ir_rx = 1'b0; step(); step();
    chk(uart_rxd === 1'b0, "R1 rx in IR mode", int'(uart_rxd), 0);
    idle(1600);

    // R2: divisor bytes and tick spacing
    set_div(5);   idle(4); tick_period(per); chk(per == 5,   "R2 div 5", per, 5);
    set_div(300); idle(4); tick_period(per); chk(per == 300, "R2 div high byte", per, 300);
    set_div(0);   idle(4); tick_period(per); chk(per == 1,   "R2 div zero", per, 1);

    // R3: divisor held while busy
    set_div(4); idle(4);
    tx_busy = 1'b1;
    set_div(9); idle(4);
    tick_period(per); chk(per == 4, "R3 busy hold", per, 4);
    tx_busy = 1'b0; idle(2);
    tick_period(per); chk(per == 9, "R3 idle adopt", per, 9);

    // Transmit encoder: directed corners
    tx_frame(8'h00, 2, 1'b0, 1'b0, "R4 all zeros");
    tx_frame(8'hFF, 3, 1'b0, 1'b0, "R4 all ones");
    tx_frame(8'hA5, 2, 1'b1, 1'b0, "R5 fixed width");
    tx_frame(8'h3C, 3, 1'b0, 1'b1, "R6 inverted");
    tx_frame(8'h00, 4, 1'b1, 1'b1, "R6 fixed inverted");
    for (int i = 0; i < 6; i++)
      tx_frame(8'($urandom), 2 + int'($urandom % 3), 1'($urandom), 1'($urandom), "R4 random");

    // R7: transmit passthrough ignores invert
    wr(2'd2, ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      r = int'($urandom % 2);
      uart_txd = 1'(r);
      step();
      if (ir_tx !== 1'(r)) bad++;
    end
    chk(bad == 0, "R7 passthrough mismatches", bad, 0);
    uart_txd = 1'b1;

    // Receive decoder
    rx_frame(8'h00, 2, 1'b0, "R8 all zeros");
    rx_frame(8'h5A, 3, 1'b1, "R9 inverted");
    for (int i = 0; i < 6; i++)
      rx_frame(8'($urandom), 2 + int'($urandom % 3), 1'($urandom), "R8 random");

    // R10: raw receive passthrough ignores invert
    wr(2'd2, ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    bad = 0; h0 = 0; h1 = 0; h2 = 0;
    for (int i = 0; i < 64; i++) begin
      r = int'($urandom % 2);
      ir_rx = 1'(r);
      step();
      h2 = h1; h1 = h0; h0 = r;
      if (i >= 3 && uart_rxd !== 1'(h2)) bad++;
    end
    chk(bad == 0, "R10 passthrough mismatches", bad, 0);

    // R11: sub-cycle glitches ignored
    set_div(2);
    wr(2'd2, ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    ir_rx = 1'b0;
    idle(100);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (i < 5) begin ir_rx = 1'b1; #1; ir_rx = 1'b0; end
      step();
      if (uart_rxd !== 1'b1) bad++;
    end
    chk(bad == 0, "R11 glitch zeros", bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule